// File: doc/BRIEF.md
# Read-Address Sequence Store Trigger

This block observes the stream of completed memory accesses on a byte-wide array with a 15-bit address (32768 locations). It looks for one exact, ordered series of six read addresses. When the sixth read of the series arrives in order, the block issues a one-clock request that tells the nonvolatile transfer sequencer to copy the array into its nonvolatile backing store.

Each access is presented for one clock as a valid strobe, together with its address and a flag that marks it as a read or a write. The block only watches. It never stalls or alters the access, so ordinary reads still return their data. A write, or a read of any address other than the next one expected, abandons the series. A read of the first key address always counts as the first step of a fresh attempt. While a store or recall transfer is in progress, the series is cleared and every access is ignored.

Top module: `rdseq_store_detect`

## Requirements
- R1: An access is taken at a rising clock edge only when `acc_valid` is high. Clocks with `acc_valid` low leave the tracked progress unchanged, so idle gaps of any length between the six reads do not break the series.
- R2: The series is six reads of these addresses, in this order: 0x0E38, 0x31C7, 0x03E0, 0x3C1F, 0x303F, 0x0FC0.
- R3: When the read of 0x0FC0 is accepted as the sixth step, `store_req` is high in the clock cycle that directly follows that access edge.
- R4: A write access (`acc_is_read` low) at any point returns the tracker to idle, whatever its address. Completing the remaining reads afterwards produces no request.
- R5: A read of an address that is neither the next expected address nor 0x0E38 returns the tracker to idle.
- R6: `store_req` is high for exactly one clock per completed series.
- R7: A read of 0x0E38 that is not the expected next address makes the tracker stand at step one of a new attempt. The five remaining reads then complete the series.
- R8: After a request the tracker is idle. Reads of the last five addresses alone do not produce another request.
- R9: While `nv_busy` is high, accesses are ignored, the tracker returns to idle and no request is raised.
- R10: Synchronous active-low reset clears `store_req` and discards any partial series.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| acc_valid | input | 1 | One-clock strobe marking a completed access |
| acc_is_read | input | 1 | 1 = read access, 0 = write access |
| acc_addr | input | 15 | Address of the access |
| nv_busy | input | 1 | A store or recall transfer is in progress |
| store_req | output | 1 | One-clock request to start a nonvolatile store |

## Verification
The bench sweeps each abort position in the series. At every position it injects a write, a read of each address one bit away from the expected key, an access while `nv_busy` is high, and a stray read of the first key. This exposes a tracker that ignores writes, or that compares only part of the address, because either would then fire a request that should never appear. The restart case catches a design that drops the stray first-key read and demands a seventh read. The back-to-back and suffix-only cases catch a tracker that does not return to idle after firing, and a pulse stretched past one clock. Idle gaps inside the series, and a reset in the middle of it, catch progress that is lost on an empty cycle or kept across reset.

// File: rtl/rdseq_pkg.sv
// Shared constants for the read-address sequence store trigger.
// Assumes a 15-bit byte address and a six-step key series.
package rdseq_pkg;

    localparam int ADDR_W    = 15;
    localparam int CHAIN_LEN = 6;
    localparam int STEP_W    = (CHAIN_LEN > 1) ? $clog2(CHAIN_LEN) : 1;

    // Key address for a given step of the series; step order is behaviour.
    function automatic logic [ADDR_W-1:0] chain_key(input int unsigned idx);
        case (idx)
            0:       chain_key = 15'h0E38;
            1:       chain_key = 15'h31C7;
            2:       chain_key = 15'h03E0;
            3:       chain_key = 15'h3C1F;
            4:       chain_key = 15'h303F;
            5:       chain_key = 15'h0FC0;
            default: chain_key = '0;
        endcase
    endfunction

endpackage

// File: rtl/rdseq_key_table.sv
// Constant key table: gives the address expected at the current step and
// the address that opens a new attempt. Assumes step_i < LEN.
module rdseq_key_table #(
    parameter int AW  = rdseq_pkg::ADDR_W,
    parameter int LEN = rdseq_pkg::CHAIN_LEN,
    parameter int SW  = rdseq_pkg::STEP_W
) (
    input  logic [SW-1:0] step_i,
    output logic [AW-1:0] next_key_o,
    output logic [AW-1:0] first_key_o
);

    logic [AW-1:0] key_rom [LEN];

    // One constant entry per step of the series.
    for (genvar g = 0; g < LEN; g++) begin : g_key
        assign key_rom[g] = AW'(rdseq_pkg::chain_key(g));
    end

    // Select the entry for the current step.
    always_comb begin
        next_key_o = '0;
        for (int i = 0; i < LEN; i++) begin
            if (step_i == SW'(i)) next_key_o = key_rom[i];
        end
    end

    assign first_key_o = key_rom[0];

endmodule

// File: rtl/rdseq_step_tracker.sv
// Step counter for the key series. It advances on a matching read, restarts
// at step one on a read of the first key, and returns to idle on any other
// access or while a transfer is busy. done_o flags the completing read.
// Assumes at most one access per clock.
module rdseq_step_tracker #(
    parameter int AW  = rdseq_pkg::ADDR_W,
    parameter int LEN = rdseq_pkg::CHAIN_LEN,
    parameter int SW  = rdseq_pkg::STEP_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_valid,
    input  logic          acc_is_read,
    input  logic [AW-1:0] acc_addr,
    input  logic          nv_busy,
    input  logic [AW-1:0] next_key,
    input  logic [AW-1:0] first_key,
    output logic [SW-1:0] step_o,
    output logic          done_o
);

    localparam logic [SW-1:0] LAST_STEP = SW'(LEN - 1);

    logic [SW-1:0] step_q;
    logic [SW-1:0] step_d;
    logic          take_read;
    logic          hit_next;
    logic          hit_first;
    logic          at_last;

    // Qualify the access and compare it with the two candidate keys.
    always_comb begin
        take_read = acc_valid && !nv_busy && acc_is_read;
        hit_next  = take_read && (acc_addr == next_key);
        hit_first = take_read && (acc_addr == first_key);
        at_last   = (step_q == LAST_STEP);
    end

    // Next-step selection.
    always_comb begin
        if (nv_busy) begin
            step_d = '0;
        end else if (!acc_valid) begin
            step_d = step_q;
        end else if (hit_next) begin
            step_d = at_last ? '0 : step_q + SW'(1);
        end else if (hit_first) begin
            step_d = SW'(1);
        end else begin
            step_d = '0;
        end
    end

    // Step register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) step_q <= '0;
        else        step_q <= step_d;
    end

    assign step_o = step_q;
    assign done_o = hit_next && at_last;

endmodule

// File: rtl/rdseq_req_pulse.sv
// Registers the completion flag into a one-clock store request.
// Assumes done_i is high for at most one clock per completed series.
module rdseq_req_pulse (
    input  logic clk,
    input  logic rst_n,
    input  logic done_i,
    output logic req_o
);

    // Output register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) req_o <= 1'b0;
        else        req_o <= done_i;
    end

endmodule

// File: rtl/rdseq_store_detect.sv
// Top level: watches completed accesses for the six-read key series and
// raises store_req for one clock once the series completes. It is passive
// and never alters the accesses it observes.
module rdseq_store_detect #(
    parameter int AW  = rdseq_pkg::ADDR_W,
    parameter int LEN = rdseq_pkg::CHAIN_LEN
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_valid,
    input  logic          acc_is_read,
    input  logic [AW-1:0] acc_addr,
    input  logic          nv_busy,
    output logic          store_req
);

    localparam int SW = (LEN > 1) ? $clog2(LEN) : 1;

    logic [SW-1:0] step_q;
    logic [AW-1:0] next_key;
    logic [AW-1:0] first_key;
    logic          chain_done;

    rdseq_key_table #(.AW(AW), .LEN(LEN), .SW(SW)) u_keys (
        .step_i      (step_q),
        .next_key_o  (next_key),
        .first_key_o (first_key)
    );

    rdseq_step_tracker #(.AW(AW), .LEN(LEN), .SW(SW)) u_tracker (
        .clk         (clk),
        .rst_n       (rst_n),
        .acc_valid   (acc_valid),
        .acc_is_read (acc_is_read),
        .acc_addr    (acc_addr),
        .nv_busy     (nv_busy),
        .next_key    (next_key),
        .first_key   (first_key),
        .step_o      (step_q),
        .done_o      (chain_done)
    );

    rdseq_req_pulse u_pulse (
        .clk    (clk),
        .rst_n  (rst_n),
        .done_i (chain_done),
        .req_o  (store_req)
    );

endmodule

// File: rtl/rdseq_store_detect_chk.sv
// Property checker for the store trigger, attached to the top by bind.
module rdseq_store_detect_chk #(
    parameter int AW  = rdseq_pkg::ADDR_W,
    parameter int LEN = rdseq_pkg::CHAIN_LEN,
    parameter int SW  = rdseq_pkg::STEP_W
) (
    input logic          clk,
    input logic          rst_n,
    input logic          acc_valid,
    input logic          acc_is_read,
    input logic [AW-1:0] acc_addr,
    input logic          nv_busy,
    input logic          store_req,
    input logic [SW-1:0] step_q
);

    localparam logic [AW-1:0] LAST_KEY = AW'(rdseq_pkg::chain_key(LEN - 1));

    // R6
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        store_req |=> !store_req);

    // R3
    req_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        store_req |-> $past(acc_valid && acc_is_read && !nv_busy && acc_addr == LAST_KEY));

    // R9
    busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nv_busy |=> (!store_req && step_q == '0));

    // R4
    write_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_is_read) |=> (step_q == '0));

    // R8
    idle_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        store_req |-> (step_q == '0));

    // R1
    gap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_valid && !nv_busy) |=> $stable(step_q));

    // R2
    step_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_q < SW'(LEN));

endmodule

bind rdseq_store_detect rdseq_store_detect_chk #(.AW(AW), .LEN(LEN), .SW(SW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_valid   (acc_valid),
    .acc_is_read (acc_is_read),
    .acc_addr    (acc_addr),
    .nv_busy     (nv_busy),
    .store_req   (store_req),
    .step_q      (step_q)
);

// File: tb/rdseq_store_detect_bench.sv
module rdseq_store_detect_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_is_read = 1'b0;
    logic [14:0] acc_addr = '0;
    logic        nv_busy = 1'b0;
    logic        store_req;

    always #5 clk = ~clk;

    rdseq_store_detect u_rdseq_store_detect (
        .clk         (clk),
        .rst_n       (rst_n),
        .acc_valid   (acc_valid),
        .acc_is_read (acc_is_read),
        .acc_addr    (acc_addr),
        .nv_busy     (nv_busy),
        .store_req   (store_req)
    );

    // R2: key series written out independently of the design
    localparam logic [14:0] KEY [6] = '{15'h0E38, 15'h31C7, 15'h03E0,
                                        15'h3C1F, 15'h303F, 15'h0FC0};

    int   n_chk = 0;
    int   n_fail = 0;
    int   pulses = 0;
    int   doubles = 0;
    logic prev_req = 1'b0;

    // Count request pulses and back-to-back highs, sampled mid-cycle.
    always @(negedge clk) begin
        if (store_req) pulses++;
        if (store_req && prev_req) doubles++;
        prev_req = store_req;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One access held for one clock edge.
    task automatic drive(input logic rd, input logic [14:0] a, input logic busy);
        @(negedge clk);
        acc_valid   = 1'b1;
        acc_is_read = rd;
        acc_addr    = a;
        nv_busy     = busy;
        @(posedge clk);
        #1;
        acc_valid   = 1'b0;
        acc_is_read = 1'b1;
        acc_addr    = ~a;
        nv_busy     = 1'b0;
    endtask

    task automatic gap(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic keys_from(input int lo, input int hi);
        for (int i = lo; i <= hi; i++) drive(1'b1, KEY[i], 1'b0);
    endtask

    // kind: 0 none, 1 write xaddr, 2 read xaddr, 3 read xaddr while busy
    task automatic scenario(input int pre, input int kind, input logic [14:0] xaddr,
                            input int resume, input int exp, input string req);
        drive(1'b0, 15'h0000, 1'b0);
        gap(2);
        pulses = 0;
        keys_from(0, pre - 1);
        case (kind)
            1: drive(1'b0, xaddr, 1'b0);
            2: drive(1'b1, xaddr, 1'b0);
            3: drive(1'b1, xaddr, 1'b1);
            default: ;
        endcase
        keys_from(resume, 5);
        gap(3);
        check(pulses == exp, req, pulses, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(store_req == 1'b0, "R10 reset", store_req, 0);
        @(negedge clk);
        rst_n = 1'b1;
        gap(2);

        // R3 exact timing, R6 single-cycle width
        pulses = 0;
        keys_from(0, 5);
        check(store_req == 1'b1, "R3 request after sixth read", store_req, 1);
        @(posedge clk);
        #1;
        check(store_req == 1'b0, "R6 request width", store_req, 0);

        // R1 idle gaps inside the series
        drive(1'b0, 15'h0000, 1'b0);
        pulses = 0;
        for (int i = 0; i < 6; i++) begin
            drive(1'b1, KEY[i], 1'b0);
            gap(1 + (i % 3));
        end
        check(pulses == 1, "R1 gaps keep progress", pulses, 1);

        // Sweep abort positions
        for (int p = 0; p < 6; p++) begin
            // R4 write to the expected address
            scenario(p, 1, KEY[p], p, (p == 0) ? 1 : 0, "R4 write aborts");
            // R9 busy access to the expected address
            scenario(p, 3, KEY[p], p, (p == 0) ? 1 : 0, "R9 busy ignored");
            // R5 every single-bit neighbour of the expected key
            for (int b = 0; b < 15; b++) begin
                logic [14:0] wrong;
                int          e;
                wrong = KEY[p] ^ (15'h1 << b);
                e = (p == 0) ? 1 : ((wrong == KEY[0] && p == 1) ? 1 : 0);
                scenario(p, 2, wrong, p, e, "R5 wrong read aborts");
            end
            // R7 stray first-key read restarts at step one
            scenario(p, 2, KEY[0], 1, 1, "R7 restart on first key");
        end

        // R8 suffix alone after a request
        scenario(6, 0, 15'h0, 1, 1, "R8 suffix after request");

        // R6 two series back to back
        drive(1'b0, 15'h0000, 1'b0);
        pulses = 0;
        keys_from(0, 5);
        keys_from(0, 5);
        gap(3);
        check(pulses == 2, "R6 two series two pulses", pulses, 2);

        // R9 busy held with no access clears progress
        drive(1'b0, 15'h0000, 1'b0);
        pulses = 0;
        keys_from(0, 2);
        @(negedge clk);
        nv_busy = 1'b1;
        @(negedge clk);
        nv_busy = 1'b0;
        keys_from(3, 5);
        gap(3);
        check(pulses == 0, "R9 busy clears progress", pulses, 0);

        // R10 reset in the middle of a series
        pulses = 0;
        keys_from(0, 4);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        keys_from(5, 5);
        gap(3);
        check(pulses == 0, "R10 reset discards progress", pulses, 0);

        check(doubles == 0, "R6 no stretched pulse", doubles, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule